// File: doc/BRIEF.md
# Three-Wire Control Word Receiver

This block receives an 18-bit tuning control word over three slow wires: a serial clock, a load enable and a data line. All three wires are asynchronous to the system clock. They pass through two-flop synchronizers, and the edges are detected in the system clock domain. A bit is taken on each falling edge of the serial clock while the enable is high. The data line is active-low, and bits arrive least significant first.

When the enable drops, the block checks how many bits came in. If exactly eighteen arrived, the shifted word moves into a holding register. The register is decoded into:
- a 14-bit division ratio,
- a charge-current select,
- a NORM level,
- a one-hot group of four band outputs.

Any other bit count leaves the holding register untouched and raises a one-cycle error pulse.

Top module: `ctlword_rx`

## Requirements
- R1: A word commits only if exactly 18 bits were captured since the enable rose. Any other count keeps every decoded output unchanged and drives `word_err` high for exactly one system cycle.
- R2: A bit is captured only on a falling edge of `ser_clk` while `ser_en` is high. Serial clock edges while `ser_en` is low have no effect.
- R3: The data line is inverted: a low level on `ser_dat` is a logic 1 and a high level is a logic 0.
- R4: `ratio` is made from received bits 1 to 14, with bit 1 as its LSB. The first five bits are the low (swallow) part, and the next nine bits are the high (main) part.
- R5: Received bit 15 drives `cp_high`. Logic 1 means the tenfold charge current and logic 0 means the single current.
- R6: Received bit 16 drives `norm_out`.
- R7: Received bits 17 and 18 form the band code, with bit 17 as its LSB. `band_oh[code]` is the only high band output.
- R8: After reset: `ratio` is 0, `cp_high` is 0, `norm_out` is 0, `band_oh` is 4'b0001 and `word_err` is 0.
- R9: The decoded outputs change only in the system cycle after the synchronized enable is seen to fall. They do not change while bits are still being shifted in.
- R10: The line sequence H L H H H L L L L L H H H L, sent for the ratio bits, yields a ratio of 9186.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock; bits are taken on its falling edge |
| ser_en | input | 1 | Load enable; high while shifting, its falling edge commits |
| ser_dat | input | 1 | Serial data, active-low, LSB first |
| ratio | output | 14 | Division ratio from the committed word |
| cp_high | output | 1 | Charge current select (1 = tenfold) |
| norm_out | output | 1 | NORM output level |
| band_oh | output | 4 | One-hot band selector outputs |
| word_err | output | 1 | One-cycle pulse when a word of wrong length is dropped |

## Verification
The bench sweeps all sixteen combinations of band code, current select and NORM, each with a different ratio pattern. A receiver that lost the inversion or reversed the bit order would garble every field, and a wrong band decode would light the wrong output.

Words of 17 and 19 bits are sent to test the length check. A receiver without that check would commit a shifted word or fail to pulse the error output.

Serial clock pulses are also sent while the enable is low. The outputs are compared in the middle of a word and once more after the enable falls. These checks catch a receiver that counts idle edges or updates the outputs too early. The 9186 line pattern is sent as a fixed known answer.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;
  parameter int WORD_W   = 18;
  parameter int RATIO_W  = 14;
  parameter int BAND_W   = 2;
  parameter int N_BANDS  = 1 << BAND_W;
  parameter int SYNC_LEN = 2;
  parameter int CNT_W    = $clog2(WORD_W + 2);

  localparam int CP_POS   = RATIO_W;
  localparam int NORM_POS = RATIO_W + 1;
  localparam int BAND_LO  = RATIO_W + 2;

  typedef struct packed {
    logic [BAND_W-1:0]  band;
    logic               norm;
    logic               cp;
    logic [RATIO_W-1:0] ratio;
  } ctl_fields_t;
endpackage

// File: rtl/ctlword_sync.sv
module ctlword_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ctlword_shift.sv
module ctlword_shift
  import ctlword_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sen_s,
  input  logic              sdat_s,
  output logic [WORD_W-1:0] shift_q,
  output logic              en_fall,
  output logic              commit,
  output logic              len_bad
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic              clk_prev, en_prev;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sr_d;
  logic              clk_fall, take_bit;

  assign clk_fall = clk_prev & ~sclk_s;
  assign en_fall  = en_prev & ~sen_s;
  assign take_bit = clk_fall & sen_s;
  assign commit   = en_fall & (cnt_q == CNT_FULL);
  assign len_bad  = en_fall & (cnt_q != CNT_FULL);

  always_comb begin
    sr_d  = shift_q;
    cnt_d = cnt_q;
    if (!sen_s) begin
      cnt_d = '0;
    end else if (take_bit) begin
      sr_d = {~sdat_s, shift_q[WORD_W-1:1]};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b0;
      en_prev  <= 1'b0;
      cnt_q    <= '0;
      shift_q  <= '0;
    end else begin
      clk_prev <= sclk_s;
      en_prev  <= sen_s;
      cnt_q    <= cnt_d;
      if (take_bit) shift_q <= sr_d;
    end
  end
endmodule

// File: rtl/ctlword_decode.sv
module ctlword_decode
  import ctlword_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  output logic [RATIO_W-1:0] ratio,
  output logic               cp_high,
  output logic               norm_out,
  output logic [N_BANDS-1:0] band_oh
);
  ctl_fields_t f;
  assign f        = ctl_fields_t'(word);
  assign ratio    = f.ratio;
  assign cp_high  = f.cp;
  assign norm_out = f.norm;

  genvar b;
  generate
    for (b = 0; b < N_BANDS; b++) begin : g_band
      assign band_oh[b] = (f.band == BAND_W'(b));
    end
  endgenerate
endmodule

// File: rtl/ctlword_rx.sv
module ctlword_rx
  import ctlword_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_en,
  input  logic               ser_dat,
  output logic [RATIO_W-1:0] ratio,
  output logic               cp_high,
  output logic               norm_out,
  output logic [N_BANDS-1:0] band_oh,
  output logic               word_err
);
  logic [2:0]        sync_q;
  logic [WORD_W-1:0] shift_q, hold_q, hold_d;
  logic              en_fall, commit, len_bad, err_d;

  ctlword_sync #(.W(3), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_dat, ser_en, ser_clk}), .q(sync_q)
  );

  ctlword_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sync_q[0]), .sen_s(sync_q[1]), .sdat_s(sync_q[2]),
    .shift_q(shift_q), .en_fall(en_fall), .commit(commit), .len_bad(len_bad)
  );

  always_comb begin
    hold_d = hold_q;
    if (commit) hold_d = shift_q;
    err_d = len_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      word_err <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      word_err <= err_d;
    end
  end

  ctlword_decode u_dec (
    .word(hold_q), .ratio(ratio), .cp_high(cp_high),
    .norm_out(norm_out), .band_oh(band_oh)
  );
endmodule

// File: rtl/ctlword_rx_chk.sv
module ctlword_rx_chk
  import ctlword_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               en_fall,
  input logic               word_err,
  input logic [RATIO_W-1:0] ratio,
  input logic               cp_high,
  input logic               norm_out,
  input logic [N_BANDS-1:0] band_oh
);
  logic [RATIO_W+N_BANDS+1:0] outs;
  assign outs = {ratio, cp_high, norm_out, band_oh};

  AST_BAND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(band_oh) == 1); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_err |=> !word_err); // R1
  AST_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    word_err |-> $stable(outs)); // R1
  AST_CHANGE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outs) |-> $past(en_fall)); // R9
endmodule

bind ctlword_rx ctlword_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_fall(en_fall), .word_err(word_err),
  .ratio(ratio), .cp_high(cp_high), .norm_out(norm_out), .band_oh(band_oh)
);

// File: tb/ctlword_rx_bench.sv
module ctlword_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_en = 1'b0, ser_dat = 1'b1;
  logic [13:0] ratio;
  logic cp_high, norm_out, word_err;
  logic [3:0] band_oh;

  int n_chk = 0, n_bad = 0, err_seen = 0, err_exp = 0;
  logic [17:0] cur = '0;

  always #2 clk = ~clk;

  ctlword_rx u_ctlword_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_dat(ser_dat), .ratio(ratio), .cp_high(cp_high),
    .norm_out(norm_out), .band_oh(band_oh), .word_err(word_err)
  );

  always @(posedge clk) if (rst_n && word_err) err_seen++;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // lines[i] is the wire level of the i-th transmitted bit
  task automatic shift_lines(input logic [31:0] lines, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = lines[i];
      wait_n(4);
      ser_clk = 1'b1;
      wait_n(4);
      ser_clk = 1'b0;
      wait_n(4);
    end
  endtask

  task automatic send(input logic [31:0] lines, input int nbits);
    ser_en = 1'b1;
    wait_n(4);
    shift_lines(lines, nbits);
    ser_en = 1'b0;
    wait_n(8);
  endtask

  task automatic check_outs(input string tag, input logic [17:0] w);
    chk({tag, " R4 ratio"}, 32'(ratio), 32'(w[13:0]));
    chk({tag, " R5 cp"}, 32'(cp_high), 32'(w[14]));
    chk({tag, " R6 norm"}, 32'(norm_out), 32'(w[15]));
    chk({tag, " R7 band"}, 32'(band_oh), 32'(4'b0001 << w[17:16]));
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R8 ratio", 32'(ratio), 0);
    chk("R8 cp", 32'(cp_high), 0);
    chk("R8 norm", 32'(norm_out), 0);
    chk("R8 band", 32'(band_oh), 32'h1);
    chk("R8 err", 32'(word_err), 0);

    // R2 R3 R4 R5 R6 R7: sweep all band/cp/norm combinations
    for (int k = 0; k < 16; k++) begin
      logic [17:0] w;
      w = {2'(k >> 2), 1'(k >> 1), 1'(k), 14'((k * 1237 + 5) * 3 + k * 4096)};
      send(32'(~w), 18);
      cur = w;
      check_outs("sweep", cur);
      chk("R1 no err", 32'(err_seen), 32'(err_exp));
    end

    // R10: known line pattern H L H H H L L L L L H H H L, then cp=1 norm=0 band=2
    begin
      logic [31:0] lines;
      string pat;
      pat = "HLHHHLLLLLHHHLLHHL";
      lines = '0;
      for (int i = 0; i < 18; i++) lines[i] = (pat[i] == "H");
      send(lines, 18);
      chk("R10 ratio", 32'(ratio), 9186);
      chk("R10 R5 cp", 32'(cp_high), 1);
      chk("R10 R7 band", 32'(band_oh), 32'h4);
      cur = {2'b10, 1'b0, 1'b1, 14'd9186};
    end

    // R1: short and long words are dropped
    send(32'h0, 17);
    err_exp++;
    chk("R1 err 17", 32'(err_seen), 32'(err_exp));
    check_outs("R1 hold17", cur);
    send(32'h0, 19);
    err_exp++;
    chk("R1 err 19", 32'(err_seen), 32'(err_exp));
    check_outs("R1 hold19", cur);

    // R2: clock pulses with enable low are ignored
    shift_lines(32'h0, 5);
    begin
      logic [17:0] w;
      w = 18'h2_A5C3;
      send(32'(~w), 18);
      cur = w;
      check_outs("R2 idle edges", cur);
    end

    // R9: mid-word, outputs stay at the old word
    begin
      logic [17:0] w;
      w = 18'h1_3F0A;
      ser_en = 1'b1;
      wait_n(4);
      shift_lines(32'(~w), 10);
      check_outs("R9 midword", cur);
      shift_lines(32'(~w) >> 10, 8);
      check_outs("R9 before fall", cur);
      ser_en = 1'b0;
      wait_n(8);
      cur = w;
      check_outs("R9 after fall", cur);
    end
    chk("R1 err total", 32'(err_seen), 32'(err_exp));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule